// File: doc/BRIEF.md
# Two-Channel Alarm Output with Programmable Hysteresis

This block turns digitised temperature and current-sense readings from two channels into a single alarm pin drive and four per-source flags. Each of the four sources has its own upper threshold. A source's condition sets as soon as a qualified sample rises above its threshold. It releases only once a sample falls below the threshold by more than a programmable hysteresis band. The band is one of four power-of-two widths.

A registered configuration word, written with a one-cycle enable, sets the following:
- whether the flags follow the live conditions (comparator mode) or latch until a host clear strobe (interrupt mode);
- the pin's active level;
- whether the pin is driven push-pull or as an open-drain output;
- whether channel 2's temperature alarm watches the internal die sensor. In that case channel 2's current-sense alarm is switched off.

The block has no analog sensing or conversion. Samples arrive already converted, each with its own valid strobe.

Top module: `alarm_hyst_ctrl`

## Requirements
- R1: After reset every configuration bit is 0: comparator mode off (interrupt mode), active-high, push-pull, hysteresis code 0, external channel 2 sensor. All flags read 0, `alarm_o` is 0 and `alarm_oe` is 1.
- R2: A source condition sets on the clock edge where a valid sample is strictly greater than that source's threshold. A sample equal to the threshold does not set it.
- R3: A set condition clears only on a valid sample strictly below threshold minus hysteresis. The hysteresis is 8, 16, 32 or 64 LSBs for `cfg_word[3:2]` = 0, 1, 2 or 3.
- R4: A sample presented while its valid strobe is low has no effect on the conditions.
- R5: With `cfg_word[4]` = 1 (comparator mode), each flag equals its source's live condition.
- R6: With `cfg_word[4]` = 0 (interrupt mode), a flag stays 1 after its condition clears, until a `clr` pulse. A `clr` pulse while the condition is still set leaves the flag at 1.
- R7: The alarm is active exactly when any flag is 1. Flag bits are 0 = channel 1 temperature, 1 = channel 1 current, 2 = channel 2 temperature, 3 = channel 2 current.
- R8: `cfg_word[1]` = 1 makes the active alarm level low; 0 makes it high.
- R9: With `cfg_word[0]` = 1 (open-drain), `alarm_o` is 0 and `alarm_oe` is 1 only while the pin level is low. With `cfg_word[0]` = 0, `alarm_oe` is always 1 and `alarm_o` carries the level.
- R10: With `cfg_word[5]` = 1, the channel 2 temperature condition compares `itemp_val` (qualified by `itemp_vld`) against threshold 2 and ignores source 2's external sample. Source 3's condition and flag are forced to 0.
- R11: `cfg_word` is captured only on a cycle with `cfg_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_word | input | 6 | Configuration: [0] open-drain, [1] active-low, [3:2] hysteresis code, [4] comparator mode, [5] channel 2 internal sensor |
| smp_val | input | 4*W | Sample value for each source |
| smp_vld | input | 4 | Sample valid strobe for each source |
| itemp_val | input | W | Internal temperature sample |
| itemp_vld | input | 1 | Internal temperature valid strobe |
| thr | input | 4*W | Upper threshold for each source |
| clr | input | 1 | Interrupt clear strobe |
| alarm_o | output | 1 | Alarm pin output value |
| alarm_oe | output | 1 | Alarm pin output enable |
| flag | output | 4 | Flag for each source |

## Verification
The assertions take for granted that thresholds stay steady while a source's condition is being tracked. They also assume the configuration word changes only through `cfg_we`, so the hysteresis and the channel 2 source selection at a sampling edge are those registered earlier. The stimulus keeps every threshold at 100 or higher so that threshold minus hysteresis never wraps. It changes configuration only between sample bursts. It reaches every source and every hysteresis code with samples exactly on the band edges.

// File: rtl/alarm_hyst_ctrl.sv
module alarm_hyst_ctrl #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [5:0]          cfg_word,
  input  logic [3:0][W-1:0]   smp_val,
  input  logic [3:0]          smp_vld,
  input  logic [W-1:0]        itemp_val,
  input  logic                itemp_vld,
  input  logic [3:0][W-1:0]   thr,
  input  logic                clr,
  output logic                alarm_o,
  output logic                alarm_oe,
  output logic [3:0]          flag
);
  localparam int NSRC = 4;

  logic [5:0] cfg;
  always_ff @(posedge clk)
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_word;

  wire od      = cfg[0];
  wire act_low = cfg[1];
  wire cmp     = cfg[4];
  wire int_sel = cfg[5];

  logic [W:0] hyst;
  assign hyst = (W+1)'(8) << cfg[3:2];

  logic [NSRC-1:0][W-1:0] s_eff;
  logic [NSRC-1:0]        v_eff, en, cond, sticky;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == 2) begin : g_mux
      assign s_eff[g] = int_sel ? itemp_val : smp_val[g];
      assign v_eff[g] = int_sel ? itemp_vld : smp_vld[g];
      assign en[g]    = 1'b1;
    end else if (g == 3) begin : g_cur2
      assign s_eff[g] = smp_val[g];
      assign v_eff[g] = smp_vld[g];
      assign en[g]    = !int_sel;
    end else begin : g_plain
      assign s_eff[g] = smp_val[g];
      assign v_eff[g] = smp_vld[g];
      assign en[g]    = 1'b1;
    end

    wire above = s_eff[g] > thr[g];
    wire below = ({1'b0, s_eff[g]} + hyst) < {1'b0, thr[g]};

    always_ff @(posedge clk)
      if (!rst_n || !en[g]) cond[g] <= 1'b0;
      else if (v_eff[g]) begin
        if (above)      cond[g] <= 1'b1;
        else if (below) cond[g] <= 1'b0;
      end

    always_ff @(posedge clk)
      if (!rst_n || !en[g] || cmp) sticky[g] <= 1'b0;
      else if (clr)                sticky[g] <= 1'b0;
      else                         sticky[g] <= sticky[g] | cond[g];

    assign flag[g] = en[g] & (cmp ? cond[g] : (sticky[g] | cond[g]));

    assert_set_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] && v_eff[g] && above && !cfg_we |=> cond[g]);
    assert_hold_in_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] && cond[g] && !cfg_we && !(v_eff[g] && below) |=> cond[g]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp && flag[g] && !clr && !cfg_we |=> flag[g]);
  end

  wire active = |flag;
  wire level  = active ^ act_low;
  assign alarm_o  = od ? 1'b0 : level;
  assign alarm_oe = od ? !level : 1'b1;

  assert_cur2_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sel) |-> !flag[3]);
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg));
endmodule

// File: tb/test_alarm_hyst_ctrl.sv
module test_alarm_hyst_ctrl;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, cfg_we = 0, itemp_vld = 0, clr = 0;
  logic [5:0] cfg_word = '0;
  logic [3:0][W-1:0] smp_val = '0, thr;
  logic [3:0] smp_vld = '0;
  logic [W-1:0] itemp_val = '0;
  logic alarm_o, alarm_oe;
  logic [3:0] flag;
  int n_chk = 0, n_bad = 0;
  logic [5:0] cur_cfg = '0;

  always #10 clk = ~clk;

  alarm_hyst_ctrl #(.W(W)) i_alarm_hyst_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_word, .smp_val, .smp_vld, .itemp_val,
    .itemp_vld, .thr, .clr, .alarm_o, .alarm_oe, .flag);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pin(input string req, input logic [3:0] ef);
    logic lvl;
    lvl = (|ef) ^ cur_cfg[1];
    chk({req, " flags"}, flag, ef);
    chk({req, " pin"}, alarm_o, cur_cfg[0] ? 0 : lvl);
    chk({req, " oe"}, alarm_oe, cur_cfg[0] ? !lvl : 1);
  endtask

  task automatic set_cfg(input logic [5:0] c);
    @(negedge clk); cfg_word = c; cfg_we = 1;
    @(negedge clk); cfg_we = 0; cur_cfg = c;
  endtask

  task automatic put(input int idx, input int v);
    @(negedge clk); smp_val[idx] = W'(v); smp_vld[idx] = 1;
    @(negedge clk); smp_vld = '0;
  endtask

  task automatic put_int(input int v);
    @(negedge clk); itemp_val = W'(v); itemp_vld = 1;
    @(negedge clk); itemp_vld = 0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) thr[i] = W'(100 + 50 * i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_pin("R1 reset", 4'b0000);

    for (int h = 0; h < 4; h++) begin
      set_cfg(6'(32'h10 | (h << 2)));
      for (int i = 0; i < 4; i++) begin
        int t, hw;
        t = 100 + 50 * i; hw = 8 << h;
        put(i, t);            chk_pin("R2 equal no set", 4'b0000);
        put(i, t + 1);        chk_pin("R2 R5 R7 set", 4'(1 << i));
        @(negedge clk); smp_val[i] = 0; @(negedge clk);
        chk_pin("R4 no valid", 4'(1 << i));
        put(i, t - hw);       chk_pin("R3 band edge hold", 4'(1 << i));
        put(i, t - hw - 1);   chk_pin("R3 R5 release", 4'b0000);
      end
    end

    for (int c = 0; c < 4; c++) begin
      set_cfg(6'(32'h10 | c));
      chk_pin("R8 R9 idle", 4'b0000);
      put(0, 101);   chk_pin("R8 R9 active", 4'b0001);
      put(0, 0);     chk_pin("R8 R9 release", 4'b0000);
    end

    set_cfg(6'h00);
    put(1, 151);   chk_pin("R6 set", 4'b0010);
    put(1, 0);     chk_pin("R6 latched", 4'b0010);
    repeat (3) @(negedge clk);
    chk_pin("R6 still latched", 4'b0010);
    pulse_clr;     chk_pin("R6 cleared", 4'b0000);
    put(2, 201);   chk_pin("R6 set again", 4'b0100);
    pulse_clr;     chk_pin("R6 clear while active", 4'b0100);
    put(2, 0);     chk_pin("R6 relatch", 4'b0100);
    pulse_clr;     chk_pin("R6 final clear", 4'b0000);

    set_cfg(6'h10);
    put(3, 251);   chk_pin("R10 cur2 before", 4'b1000);
    set_cfg(6'h30);
    chk_pin("R10 cur2 forced off", 4'b0000);
    put(3, 400);   chk_pin("R10 cur2 ignored", 4'b0000);
    put(2, 300);   chk_pin("R10 external ignored", 4'b0000);
    put_int(201);  chk_pin("R10 internal sets", 4'b0100);
    put_int(200 - 8 - 1); chk_pin("R10 internal release", 4'b0000);

    set_cfg(6'h10);
    put(0, 101);
    @(negedge clk); cfg_word = 6'h12; @(negedge clk); @(negedge clk);
    chk_pin("R11 no write", 4'b0001);
    put(0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule